// File: doc/BRIEF.md
# Frame Word to Panel Pixel Unpacker

This block sits between a frame-memory fetch engine and a display timing stage. It takes 32-bit words from a valid/ready stream and turns each one into one or two pixels on a 24-lane panel data bus, also valid/ready. Four configuration inputs set the conversion. A word-length code selects 16-bit RGB565 pixels (two per word) or 24-bit pixels (one per word). A byte-valid mask zeroes unused bytes. A reduce flag trims 8-bit components to 6 bits. A bus-width code selects the panel width.

The configuration is sampled when a word is accepted. A later change therefore never alters pixels that are already queued. A flush input throws away any word that is only partly consumed, so software can reprogram the configuration from a known empty state. Words whose configuration has no valid pixel format are taken from the input and dropped. They never stall the fetch engine.

Top module: `pixel_unpacker`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: With word length code 0 (16-bit pixels), bits 15:0 of a word are emitted first and bits 31:16 second. While a pixel is pending and `out_ready` is low, `in_ready` is 0. When no pixel is pending and flush is low, `in_ready` is 1.
- R3: A 16-bit pixel on bus code 0 (16-bit) or code 1 (8-bit) appears unchanged on lanes 15:0, and lanes 23:16 are 0.
- R4: A 16-bit pixel on bus code 2 (18-bit) is widened as {red,1'b0,green,blue,1'b0} on lanes 17:0, with red at pixel bits 15:11, green at 10:5 and blue at 4:0. Lanes 23:18 are 0.
- R5: A 16-bit pixel on bus code 3 (24-bit) is output as {red,3'b0,green,2'b0,blue,3'b0}.
- R6: With word length code 3, each word gives one pixel, with red in word bits 23:16, green in 15:8 and blue in 7:0. That pixel appears on lanes 23:0 when the reduce flag is clear. Word bits 31:24 have no effect.
- R7: With the reduce flag set, a 24-bit pixel is output as {red[7:2],green[7:2],blue[7:2]} on lanes 17:0, with lanes 23:18 at 0. The flag has no effect on 16-bit pixels.
- R8: A byte whose mask bit is 0 (mask bit n covers word bits 8n+7:8n) reads as zero. In 16-bit mode, a halfword whose two mask bits are both 0 produces no pixel.
- R9: Words with word length code 1 or 2, and 24-bit words on bus code 1, are accepted and produce no pixel.
- R10: While `flush` is 1, `in_ready` is 0. In the cycle after `flush` is 1, `out_valid` is 0 and any pending pixels are discarded.
- R11: While `out_valid` is 1 and `out_ready` is 0 (no flush), `out_valid` stays 1 and `out_data` stays stable on the next cycle.
- R12: The configuration inputs are sampled when a word is accepted. Changing them while that word's pixels are pending does not alter those pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard pending data and block input |
| cfg_word_len | input | 2 | 0: 16-bit pixels, 3: 24-bit pixels, others unsupported |
| cfg_byte_mask | input | 4 | Per-byte valid mask of the input word |
| cfg_reduce18 | input | 1 | Trim 8-bit components to 6 bits |
| cfg_bus_width | input | 2 | 0: 16, 1: 8, 2: 18, 3: 24 data lanes |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | 32 | Input word from frame memory |
| out_valid | output | 1 | Pixel valid |
| out_ready | input | 1 | Pixel taken when high with out_valid |
| out_data | output | 24 | Panel data lanes |

## Verification
The checker watches the handshake rules on every cycle: output held stable under stall, input refused during flush, output empty after flush, and input readiness tied to pending pixels. Pixel formats, half order, byte masking, dropping of unsupported words and sampling of configuration at acceptance depend on data values. Only the bench's directed scenarios, with hand-computed lane patterns, can show these.

// File: rtl/unpk_pkg.sv
package unpk_pkg;

   typedef enum logic [1:0] {
      BUS_16 = 2'd0,
      BUS_8  = 2'd1,
      BUS_18 = 2'd2,
      BUS_24 = 2'd3
   } bus_e;

   typedef enum logic [1:0] {
      WL_16   = 2'd0,
      WL_RSV1 = 2'd1,
      WL_RSV2 = 2'd2,
      WL_24   = 2'd3
   } wlen_e;

   typedef struct packed {
      logic px16;
      logic reduce18;
      bus_e bus;
   } mode_t;

   localparam int unsigned PIX16_W = 16;
   localparam int unsigned PIX24_W = 24;

endpackage

// File: rtl/unpk_slot_decode.sv
module unpk_slot_decode
   import unpk_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned NBYTE = DATA_W / 8,
   localparam int unsigned NSLOT = DATA_W / PIX16_W
) (
   input  logic [DATA_W-1:0] word_in,
   input  logic [1:0]        word_len,
   input  logic [NBYTE-1:0]  byte_mask,
   input  logic              reduce18,
   input  logic [1:0]        bus_width,
   output logic [DATA_W-1:0] word_masked,
   output logic [NSLOT-1:0]  slots,
   output mode_t             mode
);

   logic [NBYTE-1:0] keep;

   always_comb begin
      keep = byte_mask;
      if (wlen_e'(word_len) == WL_24) keep[NBYTE-1] = 1'b0;
   end

   for (genvar b = 0; b < NBYTE; b++) begin : g_byte
      assign word_masked[8*b +: 8] = keep[b] ? word_in[8*b +: 8] : 8'h00;
   end

   always_comb begin
      slots = '0;
      unique case (wlen_e'(word_len))
         WL_16: begin
            for (int s = 0; s < NSLOT; s++)
               slots[s] = |byte_mask[2*s +: 2];
         end
         WL_24: slots[0] = (bus_e'(bus_width) != BUS_8);
         default: slots = '0;
      endcase
   end

   assign mode.px16     = (wlen_e'(word_len) == WL_16);
   assign mode.reduce18 = reduce18;
   assign mode.bus      = bus_e'(bus_width);

endmodule

// File: rtl/unpk_word_hold.sv
module unpk_word_hold
   import unpk_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned NSLOT = DATA_W / PIX16_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] word_in,
   input  logic [NSLOT-1:0]  slots_in,
   input  mode_t             mode_in,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] word_q,
   output mode_t             mode_q,
   output logic              sel_hi
);

   logic [NSLOT-1:0] pend_q;
   logic [NSLOT-1:0] pend_rest;
   logic             take;
   logic             last;

   assign pend_rest = pend_q & (pend_q - NSLOT'(1));
   assign out_valid = |pend_q;
   assign take      = out_valid && out_ready;
   assign last      = (pend_rest == '0);
   assign in_ready  = !flush && (!out_valid || (take && last));
   assign sel_hi    = !pend_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         word_q <= '0;
         mode_q <= '0;
      end else if (flush) begin
         pend_q <= '0;
      end else if (in_valid && in_ready) begin
         pend_q <= slots_in;
         word_q <= word_in;
         mode_q <= mode_in;
      end else if (take) begin
         pend_q <= pend_rest;
      end
   end

endmodule

// File: rtl/unpk_lane_fmt.sv
module unpk_lane_fmt
   import unpk_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LANE_W = 24
) (
   input  mode_t             mode,
   input  logic [DATA_W-1:0] word,
   input  logic              sel_hi,
   output logic [LANE_W-1:0] lanes
);

   logic [PIX16_W-1:0] p16;
   logic [4:0]         r5, b5;
   logic [5:0]         g6;
   logic [7:0]         r8, g8, b8;
   logic [PIX24_W-1:0] pix;

   assign p16 = sel_hi ? word[2*PIX16_W-1:PIX16_W] : word[PIX16_W-1:0];
   assign r5  = p16[15:11];
   assign g6  = p16[10:5];
   assign b5  = p16[4:0];
   assign r8  = word[23:16];
   assign g8  = word[15:8];
   assign b8  = word[7:0];

   always_comb begin
      if (mode.px16) begin
         unique case (mode.bus)
            BUS_18:  pix = {6'b0, r5, 1'b0, g6, b5, 1'b0};
            BUS_24:  pix = {r5, 3'b0, g6, 2'b0, b5, 3'b0};
            default: pix = {8'b0, p16};
         endcase
      end else if (mode.reduce18) begin
         pix = {6'b0, r8[7:2], g8[7:2], b8[7:2]};
      end else begin
         pix = {r8, g8, b8};
      end
   end

   assign lanes = LANE_W'(pix);

endmodule

// File: rtl/pixel_unpacker.sv
module pixel_unpacker
   import unpk_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LANE_W = 24,
   localparam int unsigned NBYTE = DATA_W / 8,
   localparam int unsigned NSLOT = DATA_W / PIX16_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [1:0]        cfg_word_len,
   input  logic [NBYTE-1:0]  cfg_byte_mask,
   input  logic              cfg_reduce18,
   input  logic [1:0]        cfg_bus_width,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [LANE_W-1:0] out_data
);

   if (DATA_W != 32) begin : g_bad_data_w
      $error("pixel_unpacker: DATA_W must be 32");
   end
   if (LANE_W < PIX24_W) begin : g_bad_lane_w
      $error("pixel_unpacker: LANE_W must be at least 24");
   end

   logic [DATA_W-1:0] word_masked;
   logic [NSLOT-1:0]  slots;
   mode_t             mode_in;
   logic [DATA_W-1:0] word_q;
   mode_t             mode_q;
   logic              sel_hi;

   unpk_slot_decode #(.DATA_W(DATA_W)) u_decode (
      .word_in     (in_data),
      .word_len    (cfg_word_len),
      .byte_mask   (cfg_byte_mask),
      .reduce18    (cfg_reduce18),
      .bus_width   (cfg_bus_width),
      .word_masked (word_masked),
      .slots       (slots),
      .mode        (mode_in)
   );

   unpk_word_hold #(.DATA_W(DATA_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .word_in   (word_masked),
      .slots_in  (slots),
      .mode_in   (mode_in),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .word_q    (word_q),
      .mode_q    (mode_q),
      .sel_hi    (sel_hi)
   );

   unpk_lane_fmt #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_fmt (
      .mode   (mode_q),
      .word   (word_q),
      .sel_hi (sel_hi),
      .lanes  (out_data)
   );

endmodule

// File: rtl/pixel_unpacker_chk.sv
module pixel_unpacker_chk #(
   parameter int unsigned LANE_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flush,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [LANE_W-1:0] out_data
);

   AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready && !flush |=> out_valid && $stable(out_data)); // R11

   AST_FLUSH_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !in_ready); // R10

   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !out_valid); // R10

   AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !in_ready); // R2

   AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid && !flush |-> in_ready); // R2

endmodule

bind pixel_unpacker pixel_unpacker_chk #(.LANE_W(LANE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .flush     (flush),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data)
);

// File: tb/pixel_unpacker_tb.sv
module pixel_unpacker_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic [1:0]  cfg_word_len = 2'd0;
   logic [3:0]  cfg_byte_mask = 4'hF;
   logic        cfg_reduce18 = 1'b0;
   logic [1:0]  cfg_bus_width = 2'd0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_data = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [23:0] out_data;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   pixel_unpacker u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .flush         (flush),
      .cfg_word_len  (cfg_word_len),
      .cfg_byte_mask (cfg_byte_mask),
      .cfg_reduce18  (cfg_reduce18),
      .cfg_bus_width (cfg_bus_width),
      .in_valid      (in_valid),
      .in_ready      (in_ready),
      .in_data       (in_data),
      .out_valid     (out_valid),
      .out_ready     (out_ready),
      .out_data      (out_data)
   );

   localparam logic [31:0] W16 = 32'hABCD_1234;
   localparam logic [31:0] W24 = 32'h5AC3_81FF;

   task automatic check_bit(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic set_cfg(input logic [1:0] wl, input logic [3:0] m,
                          input logic red, input logic [1:0] bw);
      cfg_word_len = wl; cfg_byte_mask = m; cfg_reduce18 = red; cfg_bus_width = bw;
   endtask

   task automatic push(input logic [31:0] w);
      int n = 0;
      @(negedge clk);
      in_valid = 1'b1; in_data = w;
      #1;
      while (!in_ready && n < 50) begin
         @(negedge clk); #1; n++;
      end
      if (n == 50) begin
         n_chk++; n_bad++;
         $display("FAIL R2: input never accepted, actual stall expected accept");
      end
      @(negedge clk);
      in_valid = 1'b0;
      #1;
   endtask

   task automatic pop(input string req, input logic [23:0] exp);
      out_ready = 1'b1;
      #1;
      n_chk++;
      if (!out_valid || out_data !== exp) begin
         n_bad++;
         $display("FAIL %s: actual valid=%0b data=%06h expected %06h", req, out_valid, out_data, exp);
      end
      @(negedge clk);
      out_ready = 1'b0;
      #1;
   endtask

   task automatic t_reset();
      check_bit("R1 out_valid", out_valid, 1'b0);
      check_bit("R1 in_ready", in_ready, 1'b1);
   endtask

   task automatic t_order_bus16();
      set_cfg(2'd0, 4'hF, 1'b0, 2'd0);
      push(W16);
      check_bit("R2 stalled in_ready", in_ready, 1'b0);
      pop("R2 R3 low half bus16", 24'h001234);
      pop("R2 R3 high half bus16", 24'h00ABCD);
      check_bit("R2 drained", out_valid, 1'b0);
      set_cfg(2'd0, 4'hF, 1'b1, 2'd1);
      push(W16);
      pop("R3 R7 bus8 reduce ignored", 24'h001234);
      pop("R3 bus8 high", 24'h00ABCD);
   endtask

   task automatic t_wide16();
      set_cfg(2'd0, 4'hF, 1'b0, 2'd2);
      push(W16);
      pop("R4 bus18 low", 24'h004468);
      pop("R4 bus18 high", 24'h02A79A);
      set_cfg(2'd0, 4'hF, 1'b0, 2'd3);
      push(W16);
      pop("R5 bus24 low", 24'h1044A0);
      pop("R5 bus24 high", 24'hA87868);
   endtask

   task automatic t_pix24();
      set_cfg(2'd3, 4'hF, 1'b0, 2'd3);
      push(W24);
      pop("R6 24bit raw", 24'hC381FF);
      check_bit("R6 one pixel per word", out_valid, 1'b0);
      set_cfg(2'd3, 4'h7, 1'b1, 2'd2);
      push(W24);
      pop("R7 reduce18", 24'h03083F);
      set_cfg(2'd0, 4'hF, 1'b1, 2'd0);
      push(W16);
      pop("R7 no effect on 16bit", 24'h001234);
      pop("R7 no effect on 16bit high", 24'h00ABCD);
   endtask

   task automatic t_mask();
      set_cfg(2'd3, 4'h5, 1'b0, 2'd3);
      push(W24);
      pop("R8 masked green", 24'hC300FF);
      set_cfg(2'd0, 4'h3, 1'b0, 2'd0);
      push(W16);
      pop("R8 low half only", 24'h001234);
      check_bit("R8 empty upper half skipped", out_valid, 1'b0);
      set_cfg(2'd0, 4'h6, 1'b0, 2'd0);
      push(W16);
      pop("R8 partial low", 24'h001200);
      pop("R8 partial high", 24'h0000CD);
   endtask

   task automatic t_unsupported();
      set_cfg(2'd1, 4'hF, 1'b0, 2'd0);
      push(W16);
      check_bit("R9 code1 dropped", out_valid, 1'b0);
      check_bit("R9 code1 ready", in_ready, 1'b1);
      set_cfg(2'd2, 4'hF, 1'b0, 2'd3);
      push(W16);
      check_bit("R9 code2 dropped", out_valid, 1'b0);
      set_cfg(2'd3, 4'h7, 1'b0, 2'd1);
      push(W24);
      check_bit("R9 24bit on bus8 dropped", out_valid, 1'b0);
   endtask

   task automatic t_flush();
      set_cfg(2'd0, 4'hF, 1'b0, 2'd0);
      push(W16);
      pop("R10 before flush", 24'h001234);
      flush = 1'b1;
      #1;
      check_bit("R10 in_ready during flush", in_ready, 1'b0);
      @(negedge clk);
      flush = 1'b0;
      #1;
      check_bit("R10 emptied", out_valid, 1'b0);
      push(32'h0000_0F0F);
      pop("R10 resumes with new word", 24'h000F0F);
      pop("R10 resumes high", 24'h000000);
   endtask

   task automatic t_stall();
      set_cfg(2'd3, 4'h7, 1'b0, 2'd3);
      push(W24);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); #1;
         n_chk++;
         if (!out_valid || out_data !== 24'hC381FF) begin
            n_bad++;
            $display("FAIL R11: actual valid=%0b data=%06h expected C381FF", out_valid, out_data);
         end
      end
      pop("R11 after stall", 24'hC381FF);
   endtask

   task automatic t_capture();
      set_cfg(2'd0, 4'hF, 1'b0, 2'd3);
      push(W16);
      set_cfg(2'd3, 4'h0, 1'b1, 2'd0);
      pop("R12 low uses captured cfg", 24'h1044A0);
      pop("R12 high uses captured cfg", 24'hA87868);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      t_reset();
      t_order_bus16();
      t_wide16();
      t_pix24();
      t_mask();
      t_unsupported();
      t_flush();
      t_stall();
      t_capture();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule